// File: doc/BRIEF.md
# VLIW Bundle Template Decoder

This block sits between instruction fetch and issue in a wide in-order machine. It accepts one 128-bit instruction bundle per valid/ready handshake and breaks it into the three 41-bit operations the bundle carries. The 5-bit template in the low bits of the bundle is the only source of two facts: which execution unit class each operation needs, and where instruction-group boundaries fall. A boundary can fall after an operation inside the bundle or at the end of the bundle.

The operations leave the block one per cycle, in slot order, on a valid/ready output. Each one carries its unit class and an end-of-group flag, so issue logic can collect an independent group and dispatch it together. When the second and third slots form a single long-immediate operation, they leave as one output that carries both syllables. A bundle whose template is reserved raises an illegal flag and produces no operations.

Top module: `vliw_bundle_decoder`

## Requirements
- R1: The template is bundle bits 4:0. Slot 0 is bits 45:5, slot 1 is bits 86:46 and slot 2 is bits 127:87. Operations are emitted one per handshake in ascending slot order, and `out_slot` gives the slot index.
- R2: `out_unit` is coded M=0, I=1, F=2, B=3, L=4. Templates 0–3 give M,I,I. Templates 8–11 give M,M,I. 12–13 give M,F,I. 14–15 give M,M,F. 16–17 give M,I,B. 18–19 give M,B,B. 22–23 give B,B,B. 24–25 give M,M,B. 28–29 give M,F,B.
- R3: For every odd template, the last operation of the bundle has `out_stop`=1. For an even template the last operation has `out_stop`=0, unless R4 applies.
- R4: Templates 10 and 11 set `out_stop` on the slot 0 operation. Templates 2 and 3 set it on the slot 1 operation. No other template sets `out_stop` on slot 0 or slot 1.
- R5: Templates 4 and 5 produce two operations. The first is slot 0 with unit M. The second has `out_slot`=1, unit L, `out_syl` = slot 1 and `out_ext` = slot 2. `out_ext` is zero on every other operation.
- R6: Templates 6, 7, 20, 21, 26, 27, 30 and 31 are reserved. An accepted reserved bundle raises `illegal` for exactly the one cycle after acceptance, emits nothing, and leaves `in_ready` high.
- R7: `in_ready` is low from the cycle after a legal bundle is accepted until its last operation is handshaken. It is high again in the following cycle.
- R8: While `out_valid` is high and `out_ready` is low, every output field stays unchanged.
- R9: After reset, `out_valid` and `illegal` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; synchronised internally |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Block can take a bundle |
| in_bundle | input | 128 | Template plus three syllables |
| out_valid | output | 1 | Operation present |
| out_ready | input | 1 | Downstream takes the operation |
| out_syl | output | 41 | Operation syllable |
| out_ext | output | 41 | Second syllable of a long-immediate operation, else zero |
| out_unit | output | 3 | Unit class code |
| out_slot | output | 2 | Slot index of the operation |
| out_stop | output | 1 | Operation ends an instruction group |
| illegal | output | 1 | Reserved template was dropped |

## Verification
A bundle accepted on a rising edge shows its slot 0 operation from the next cycle. Each later operation appears in the cycle after the handshake of the one before it. `illegal` is due in the single cycle after a reserved bundle is accepted, and `in_ready` returns in the cycle after the final operation's handshake. The bench drives inputs and samples outputs on falling edges. It compares against its own template table exactly at these cycle positions, and it also holds `out_ready` low for several cycles to confirm that the outputs stay frozen.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int TPL_W    = 5;
  localparam int SYL_W    = 41;
  localparam int SLOTS    = 3;
  localparam int BUNDLE_W = TPL_W + SLOTS * SYL_W;
  localparam int IDX_W    = $clog2(SLOTS);
  localparam int UNIT_W   = 3;

  typedef enum logic [UNIT_W-1:0] {
    UNIT_M = 3'd0,
    UNIT_I = 3'd1,
    UNIT_F = 3'd2,
    UNIT_B = 3'd3,
    UNIT_L = 3'd4
  } unit_e;

  typedef struct packed {
    logic                          legal;
    logic                          is_long;
    logic [SLOTS-1:0][UNIT_W-1:0]  unit;
    logic [SLOTS-1:0]              stop;
  } tpl_info_t;
endpackage

// File: rtl/vliw_tpl_decode.sv
module vliw_tpl_decode
  import vliw_pkg::*;
(
  input  logic [TPL_W-1:0] tpl,
  output tpl_info_t        info
);
  // Templates come in pairs; the upper four bits pick the unit pattern.
  function automatic logic [SLOTS-1:0][UNIT_W-1:0] pack3(unit_e a, unit_e b, unit_e c);
    pack3 = {c, b, a};
  endfunction

  always_comb begin
    info         = '0;
    info.legal   = 1'b1;
    info.is_long = 1'b0;
    unique case (tpl[TPL_W-1:1])
      4'd0, 4'd1: info.unit = pack3(UNIT_M, UNIT_I, UNIT_I);
      4'd2: begin
        info.unit    = pack3(UNIT_M, UNIT_L, UNIT_L);
        info.is_long = 1'b1;
      end
      4'd4, 4'd5: info.unit = pack3(UNIT_M, UNIT_M, UNIT_I);
      4'd6:       info.unit = pack3(UNIT_M, UNIT_F, UNIT_I);
      4'd7:       info.unit = pack3(UNIT_M, UNIT_M, UNIT_F);
      4'd8:       info.unit = pack3(UNIT_M, UNIT_I, UNIT_B);
      4'd9:       info.unit = pack3(UNIT_M, UNIT_B, UNIT_B);
      4'd11:      info.unit = pack3(UNIT_B, UNIT_B, UNIT_B);
      4'd12:      info.unit = pack3(UNIT_M, UNIT_M, UNIT_B);
      4'd14:      info.unit = pack3(UNIT_M, UNIT_F, UNIT_B);
      default:    info.legal = 1'b0;
    endcase
    // Group boundaries: low bit marks end of bundle, pairs 1 and 5 add an inner one.
    info.stop[SLOTS-1] = tpl[0];
    info.stop[1]       = (tpl[TPL_W-1:1] == 4'd1);
    info.stop[0]       = (tpl[TPL_W-1:1] == 4'd5);
  end
endmodule

// File: rtl/vliw_slot_seq.sv
module vliw_slot_seq
  import vliw_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  tpl_info_t                    info_in,
  input  logic [SLOTS-1:0][SYL_W-1:0]  syl_in,
  output logic                         busy,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [SYL_W-1:0]             out_syl,
  output logic [SYL_W-1:0]             out_ext,
  output logic [UNIT_W-1:0]            out_unit,
  output logic [IDX_W-1:0]             out_slot,
  output logic                         out_stop
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS-1);

  logic                         busy_q, busy_d;
  logic [IDX_W-1:0]             idx_q, idx_d;
  tpl_info_t                    info_q;
  logic [SLOTS-1:0][SYL_W-1:0]  syl_q;
  logic                         long_emit, last_emit, fire;

  assign long_emit = info_q.is_long && (idx_q == IDX_W'(1));
  assign last_emit = (idx_q == LAST_IDX) || long_emit;
  assign fire      = busy_q && out_ready;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (fire) begin
      if (last_emit) busy_d = 1'b0;
      else           idx_d  = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  // Payload registers carry no reset; they load only on acceptance.
  always_ff @(posedge clk) begin
    if (load) begin
      info_q <= info_in;
      syl_q  <= syl_in;
    end
  end

  assign busy      = busy_q;
  assign out_valid = busy_q;
  assign out_slot  = idx_q;
  assign out_syl   = syl_q[idx_q];
  assign out_ext   = long_emit ? syl_q[SLOTS-1] : '0;
  assign out_unit  = info_q.unit[idx_q];
  assign out_stop  = long_emit ? info_q.stop[SLOTS-1] : info_q.stop[idx_q];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_syl) && $stable(out_unit)
                                && $stable(out_slot) && $stable(out_stop) && $stable(out_ext)) // R8
    else $error("stall hold");
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_slot == '0 |=> out_valid && out_slot == IDX_W'(1)) // R1
    else $error("slot order");
  AST_FINAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_slot == LAST_IDX |=> !out_valid) // R7
    else $error("final drop");
  AST_LONG_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unit == UNIT_L |-> out_slot == IDX_W'(1)) // R5
    else $error("long slot");
endmodule

// File: rtl/vliw_bundle_decoder.sv
module vliw_bundle_decoder
  import vliw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BUNDLE_W-1:0]  in_bundle,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [SYL_W-1:0]     out_syl,
  output logic [SYL_W-1:0]     out_ext,
  output logic [UNIT_W-1:0]    out_unit,
  output logic [IDX_W-1:0]     out_slot,
  output logic                 out_stop,
  output logic                 illegal
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_ni;
  tpl_info_t                    dec_info;
  logic [SLOTS-1:0][SYL_W-1:0]  syl_split;
  logic                         busy, accept, load, illegal_q, illegal_d;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  for (genvar s = 0; s < SLOTS; s++) begin : g_split
    assign syl_split[s] = in_bundle[TPL_W + s*SYL_W +: SYL_W];
  end

  vliw_tpl_decode u_dec (
    .tpl  (in_bundle[TPL_W-1:0]),
    .info (dec_info)
  );

  assign in_ready  = !busy;
  assign accept    = in_valid && in_ready && rst_ni;
  assign load      = accept && dec_info.legal;
  assign illegal_d = accept && !dec_info.legal;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= illegal_d;
  end
  assign illegal = illegal_q;

  vliw_slot_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .load      (load),
    .info_in   (dec_info),
    .syl_in    (syl_split),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_syl   (out_syl),
    .out_ext   (out_ext),
    .out_unit  (out_unit),
    .out_slot  (out_slot),
    .out_stop  (out_stop)
  );

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_ni)
    illegal |-> !out_valid && in_ready) // R6
    else $error("illegal emitted");
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid && in_ready && in_bundle[TPL_W-1:0] == 5'd9 |=> out_valid && !in_ready && out_slot == '0) // R7
    else $error("load busy");
endmodule

// File: tb/vliw_bundle_decoder_bench.sv
`timescale 1ns/1ps
module vliw_bundle_decoder_bench;
  localparam int UM = 0, UI = 1, UF = 2, UB = 3, UL = 4;

  function automatic logic [18:0] mk(int t, int n, int a, int b, int c, int s0, int s1, int s2);
    mk = {5'(t), 2'(n), 3'(a), 3'(b), 3'(c), 1'(s0), 1'(s1), 1'(s2)};
  endfunction

  // template, emissions, unit per emission, stop per emission (n=0: reserved)
  localparam logic [18:0] VEC [20] = '{
    mk(0, 3,UM,UI,UI,0,0,0), mk(1, 3,UM,UI,UI,0,0,1), mk(2, 3,UM,UI,UI,0,1,0),
    mk(3, 3,UM,UI,UI,0,1,1), mk(4, 2,UM,UL,0, 0,0,0), mk(5, 2,UM,UL,0, 0,1,0),
    mk(9, 3,UM,UM,UI,0,0,1), mk(10,3,UM,UM,UI,1,0,0), mk(11,3,UM,UM,UI,1,0,1),
    mk(13,3,UM,UF,UI,0,0,1), mk(14,3,UM,UM,UF,0,0,0), mk(17,3,UM,UI,UB,0,0,1),
    mk(18,3,UM,UB,UB,0,0,0), mk(23,3,UB,UB,UB,0,0,1), mk(24,3,UM,UM,UB,0,0,0),
    mk(29,3,UM,UF,UB,0,0,1), mk(6, 0,0,0,0,0,0,0),    mk(7, 0,0,0,0,0,0,0),
    mk(20,0,0,0,0,0,0,0),    mk(31,0,0,0,0,0,0,0)
  };

  logic         clk = 0, rst_n = 0;
  logic         in_valid = 0, out_ready = 1;
  logic [127:0] in_bundle = '0;
  logic         in_ready, out_valid, out_stop, illegal;
  logic [40:0]  out_syl, out_ext;
  logic [2:0]   out_unit;
  logic [1:0]   out_slot;
  int           checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  vliw_bundle_decoder u_vliw_bundle_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bundle(in_bundle), .out_valid(out_valid), .out_ready(out_ready),
    .out_syl(out_syl), .out_ext(out_ext), .out_unit(out_unit), .out_slot(out_slot),
    .out_stop(out_stop), .illegal(illegal)
  );

  function automatic logic [40:0] syl(int t, int k);
    syl = {5'(t), 2'(k), 34'h25A5A1234 ^ 34'(t * 7 + k)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic offer(int t);
    @(negedge clk);
    in_bundle = {syl(t, 2), syl(t, 1), syl(t, 0), 5'(t)};
    in_valid  = 1;
    @(negedge clk);
    in_valid  = 0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R9 out_valid", 64'(out_valid), 0);
    chk("R9 illegal",   64'(illegal), 0);
    chk("R9 in_ready",  64'(in_ready), 1);

    for (int i = 0; i < 20; i++) begin
      logic [18:0] v;
      int t, n;
      logic [2:0] u [3];
      logic       s [3];
      v = VEC[i];
      t = int'(v[18:14]); n = int'(v[13:12]);
      u[0] = v[11:9]; u[1] = v[8:6]; u[2] = v[5:3];
      s[0] = v[2];    s[1] = v[1];   s[2] = v[0];
      offer(t);
      if (n == 0) begin
        chk("R6 illegal pulse", 64'(illegal), 1);
        chk("R6 no emission",   64'(out_valid), 0);
        chk("R6 ready stays",   64'(in_ready), 1);
        @(negedge clk);
        chk("R6 single cycle",  64'(illegal), 0);
        chk("R6 still silent",  64'(out_valid), 0);
      end else begin
        for (int e = 0; e < n; e++) begin
          chk("R1 valid",     64'(out_valid), 1);
          chk("R1 slot",      64'(out_slot), 64'(e));
          chk("R2 unit",      64'(out_unit), 64'(u[e]));
          chk(e == n - 1 ? "R3 end stop" : "R4 inner stop", 64'(out_stop), 64'(s[e]));
          chk("R1 syllable",  64'(out_syl), 64'(syl(t, e)));
          chk("R5 ext",       64'(out_ext), (n == 2 && e == 1) ? 64'(syl(t, 2)) : 64'(0));
          chk("R7 ready low", 64'(in_ready), 0);
          @(negedge clk);
        end
        chk("R7 idle valid", 64'(out_valid), 0);
        chk("R7 ready back", 64'(in_ready), 1);
      end
    end

    // Backpressure on a M,I,B bundle
    offer(16);
    out_ready = 0;
    for (int c = 0; c < 3; c++) begin
      chk("R8 held valid", 64'(out_valid), 1);
      chk("R8 held slot",  64'(out_slot), 0);
      chk("R8 held syl",   64'(out_syl), 64'(syl(16, 0)));
      chk("R8 held unit",  64'(out_unit), UM);
      chk("R7 ready stall", 64'(in_ready), 0);
      @(negedge clk);
    end
    out_ready = 1;
    @(negedge clk);
    chk("R1 after stall slot", 64'(out_slot), 1);
    chk("R2 after stall unit", 64'(out_unit), UI);
    @(negedge clk);
    chk("R2 slot2 unit", 64'(out_unit), UB);
    chk("R3 even no stop", 64'(out_stop), 0);
    @(negedge clk);
    chk("R7 drained", 64'(in_ready), 1);

    // Reserved right after a legal bundle: back-to-back pulse behaviour
    offer(21);
    chk("R6 reserved 21", 64'(illegal), 1);
    offer(30);
    chk("R6 reserved 30", 64'(illegal), 1);
    chk("R6 reserved 30 silent", 64'(out_valid), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule